// File: doc/BRIEF.md
# Load/Store Sequencer with Shared-Bus Fetch Stall

This block carries out one memory load or store at a time for a small in-order core. It contains the core's general register file, which has two read ports and one write port. It also contains an adder that forms the effective address, and a controller that runs the external bus. The external bus is a single multiplexed address/data path. Instruction fetch uses the same bus, so the block raises a stall signal toward the fetch unit for as long as it holds the bus.

A decoded request names a base register, an index register and one more register. For a store, that register is the data source. For a load, it is the destination. A store uses three register reads, but only two ports exist. The base and index are therefore read in the accept cycle, and the data register is read during the address phase. A load needs an address phase and a data phase on the bus, and then one write-back cycle into the register file.

Top module: `ldst_sequencer`

## Requirements
- R1: After a cycle with `rst_n` low:
  - `req_ready` is 1, and `bus_valid` and `fetch_stall` are 0.
  - Every register reads as zero.
- R2: During the address phase (`bus_valid`=1, `bus_addr_phase`=1), `bus_ad` carries the sum modulo 2^32 of the base and index register values read in the accept cycle.
- R3: A store with `bus_ready` held high takes exactly three cycles:
  - Cycle 1 is the accept cycle.
  - Cycle 2 is the address phase.
  - Cycle 3 is the data phase (`bus_addr_phase`=0), where `bus_ad` carries the data register's value.
  - `bus_write` is 1 in both phases, and `req_ready` is 1 again in the following cycle.
- R4: A load follows the same accept, address-phase and data-phase order, with `bus_write`=0.
  - The `bus_rdata` value present when the data phase is accepted is written to the destination register in the next cycle.
  - `req_ready` stays 0 during that write-back cycle.
- R5: Register 0 always reads as zero, and a load that targets it leaves it at zero.
- R6: `fetch_stall` equals 1 exactly in the cycles where `bus_valid` is 1. It is 0 in the cycle after the data phase is accepted.
- R7: While `bus_valid` is 1 and `bus_ready` is 0, the phase holds, and `bus_ad`, `bus_write` and `bus_addr_phase` keep their values.
- R8: `req_ready` is 1 only when the sequencer is idle. A request presented while `req_ready` is 0 has no effect: the running transfer's bus values are unchanged, and no extra bus transfer follows.
- R9: Reset during a transfer abandons it. In the next cycle the block is idle with `bus_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted on this cycle if valid |
| req_store | input | 1 | 1 = store, 0 = load |
| req_base | input | 5 | Base register number |
| req_index | input | 5 | Index register number |
| req_reg | input | 5 | Store data register or load destination register |
| bus_valid | output | 1 | Bus phase active |
| bus_ready | input | 1 | Bus accepts the current phase |
| bus_write | output | 1 | 1 = write transfer |
| bus_addr_phase | output | 1 | 1 = address phase, 0 = data phase |
| bus_ad | output | 32 | Multiplexed address / store data |
| bus_rdata | input | 32 | Load data, sampled when the data phase is accepted |
| fetch_stall | output | 1 | Instruction fetch must not use the bus |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath and 32 registers. With those defaults, address wrap-around at 2^32 and the hard-wired zero register can both be reached directly. Random bus-ready gaps of zero to two cycles in each phase exercise phase holding. Register reuse makes a register serve as base, index and data in one store. A reset issued in the middle of a data phase checks that the transfer is abandoned.

// File: rtl/ldst_pkg.sv
// Package: shared types of the load/store sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package ldst_pkg;

    // Controller states; the bus is owned in SEQ_ADDR and SEQ_DATA.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ADDR = 2'd1,
        SEQ_DATA = 2'd2,
        SEQ_WB   = 2'd3
    } seq_state_t;

endpackage

// File: rtl/ldst_regfile.sv
// Module: general register file, two combinational read ports and
// one synchronous write port. Entry 0 is hard-wired to zero.
// Assumes: NREGS is a power of two; reset clears all entries.
module ldst_regfile #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 32,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ra_a,
    output logic [DATA_W-1:0] rd_a,
    input  logic [AW-1:0]     ra_b,
    output logic [DATA_W-1:0] rd_b,
    input  logic              we,
    input  logic [AW-1:0]     wa,
    input  logic [DATA_W-1:0] wd
);
    logic [DATA_W-1:0] cells [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_cell
        if (g == 0) begin : g_zero
            assign cells[g] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            // Holds one register; cleared on reset, loaded on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (we && wa == AW'(g))
                    q <= wd;
            end
            assign cells[g] = q;
        end
    end

    // Two independent read ports.
    assign rd_a = cells[ra_a];
    assign rd_b = cells[ra_b];

    // R5: a write aimed at entry 0 leaves it reading zero afterwards.
    p_zero_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == '0 && ra_a == '0) |=> (ra_a != '0 || rd_a == '0));

endmodule

// File: rtl/ldst_agen.sv
// Module: effective-address adder, base plus index, wrapping at 2^DATA_W.
// Assumes: both operands come straight from the register file read ports.
module ldst_agen #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] index_val,
    output logic [DATA_W-1:0] eff_addr
);
    // Plain modular sum; carry out is discarded.
    assign eff_addr = base_val + index_val;
endmodule

// File: rtl/ldst_ctrl.sv
// Module: sequencing controller. Accepts one request when idle, runs
// address then data phase on the shared bus, and for loads performs a
// write-back cycle. Port A of the register file is steered to the data
// register during the address phase so that a store fits in two ports.
// Assumes: the request is held stable while req_valid is high in idle.
module ldst_ctrl
    import ldst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [AW-1:0]     req_reg,
    input  logic [DATA_W-1:0] eff_addr,
    input  logic [DATA_W-1:0] port_a_data,
    output logic              port_a_use_held,
    output logic [AW-1:0]     held_reg,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_write,
    output logic              bus_addr_phase,
    output logic [DATA_W-1:0] bus_ad,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              fetch_stall,
    output logic              rf_we,
    output logic [AW-1:0]     rf_wa,
    output logic [DATA_W-1:0] rf_wd
);
    seq_state_t        state;
    logic              held_store;
    logic [DATA_W-1:0] held_addr;
    logic [DATA_W-1:0] held_data;

    // State sequencing: idle -> addr -> data -> (idle | write-back).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            unique case (state)
                SEQ_IDLE: if (req_valid) state <= SEQ_ADDR;
                SEQ_ADDR: if (bus_ready) state <= SEQ_DATA;
                SEQ_DATA: if (bus_ready) state <= held_store ? SEQ_IDLE : SEQ_WB;
                SEQ_WB:   state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    // Request capture: operation, register number and effective address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_store <= 1'b0;
            held_reg   <= '0;
            held_addr  <= '0;
        end else if (state == SEQ_IDLE && req_valid) begin
            held_store <= req_store;
            held_reg   <= req_reg;
            held_addr  <= eff_addr;
        end
    end

    // Data capture: store data at end of address phase, load data at end of data phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_data <= '0;
        else if (state == SEQ_ADDR && bus_ready && held_store)
            held_data <= port_a_data;
        else if (state == SEQ_DATA && bus_ready && !held_store)
            held_data <= bus_rdata;
    end

    // Output decode from state.
    always_comb begin
        req_ready       = (state == SEQ_IDLE);
        bus_valid       = (state == SEQ_ADDR) || (state == SEQ_DATA);
        bus_addr_phase  = (state == SEQ_ADDR);
        bus_write       = bus_valid && held_store;
        fetch_stall     = bus_valid;
        port_a_use_held = (state == SEQ_ADDR);
        rf_we           = (state == SEQ_WB);
        rf_wa           = held_reg;
        rf_wd           = held_data;
        if (state == SEQ_ADDR)
            bus_ad = held_addr;
        else if (state == SEQ_DATA && held_store)
            bus_ad = held_data;
        else
            bus_ad = '0;
    end

    // R7: a phase that is not accepted holds all its bus values.
    p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_ad)
            && $stable(bus_addr_phase) && $stable(bus_write)));

    // R3: the bus is always taken with an address phase first.
    p_addr_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> bus_addr_phase);

    // R6: the stall drops in the cycle after the final data transfer.
    p_stall_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && !bus_addr_phase) |=> !fetch_stall);

    // R8: an accepted request makes the sequencer busy next cycle.
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R4: an accepted load data phase is followed by a register write.
    p_load_writeback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && !bus_addr_phase && !bus_write) |=> rf_we);

endmodule

// File: rtl/ldst_sequencer.sv
// Module: top of the load/store sequencer. Joins the register file, the
// address adder and the controller; steers read port A between the
// request's base register (idle) and the held data register (address phase).
// Assumes: one outstanding request at a time, no alignment handling.
module ldst_sequencer #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 32,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [AW-1:0]     req_base,
    input  logic [AW-1:0]     req_index,
    input  logic [AW-1:0]     req_reg,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_write,
    output logic              bus_addr_phase,
    output logic [DATA_W-1:0] bus_ad,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              fetch_stall
);
    logic [AW-1:0]     ra_a;
    logic [DATA_W-1:0] rd_a;
    logic [DATA_W-1:0] rd_b;
    logic [DATA_W-1:0] eff_addr;
    logic              use_held;
    logic [AW-1:0]     held_reg;
    logic              rf_we;
    logic [AW-1:0]     rf_wa;
    logic [DATA_W-1:0] rf_wd;

    // Port A steering: base when idle, data register during address phase.
    assign ra_a = use_held ? held_reg : req_base;

    ldst_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (ra_a),
        .rd_a  (rd_a),
        .ra_b  (req_index),
        .rd_b  (rd_b),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    ldst_agen #(.DATA_W(DATA_W)) u_agen (
        .base_val  (rd_a),
        .index_val (rd_b),
        .eff_addr  (eff_addr)
    );

    ldst_ctrl #(.DATA_W(DATA_W), .AW(AW)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_store       (req_store),
        .req_reg         (req_reg),
        .eff_addr        (eff_addr),
        .port_a_data     (rd_a),
        .port_a_use_held (use_held),
        .held_reg        (held_reg),
        .bus_valid       (bus_valid),
        .bus_ready       (bus_ready),
        .bus_write       (bus_write),
        .bus_addr_phase  (bus_addr_phase),
        .bus_ad          (bus_ad),
        .bus_rdata       (bus_rdata),
        .fetch_stall     (fetch_stall),
        .rf_we           (rf_we),
        .rf_wa           (rf_wa),
        .rf_wd           (rf_wd)
    );

    // R6: the fetch stall tracks bus ownership cycle by cycle.
    p_stall_is_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall == bus_valid);

    // R9: reset leaves the bus released on the following cycle.
    p_reset_release_r9: assert property (@(posedge clk)
        (!rst_n) |=> (!bus_valid && req_ready));

endmodule

// File: tb/ldst_sequencer_tb.sv
module ldst_sequencer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic [4:0]  req_base = '0;
    logic [4:0]  req_index = '0;
    logic [4:0]  req_reg = '0;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic        bus_write;
    logic        bus_addr_phase;
    logic [31:0] bus_ad;
    logic [31:0] bus_rdata = '0;
    logic        fetch_stall;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] exp_rf [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    ldst_sequencer u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_base(req_base), .req_index(req_index), .req_reg(req_reg),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr_phase(bus_addr_phase), .bus_ad(bus_ad),
        .bus_rdata(bus_rdata), .fetch_stall(fetch_stall)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_addr(input int b, input int i);
        return exp_rf[b] + exp_rf[i];
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    task automatic check_phase(input bit addr_ph, input bit st, input logic [31:0] exp_ad, input bit cmp_ad);
        chk(bus_valid == 1'b1, "R6 bus_valid in phase", 32'(bus_valid), 32'd1);
        chk(fetch_stall == 1'b1, "R6 fetch_stall while owning bus", 32'(fetch_stall), 32'd1);
        chk(bus_addr_phase == addr_ph, "R3 phase order", 32'(bus_addr_phase), 32'(addr_ph));
        chk(bus_write == st, "R3/R4 bus_write", 32'(bus_write), 32'(st));
        chk(req_ready == 1'b0, "R8 busy during transfer", 32'(req_ready), 32'd0);
        if (cmp_ad)
            chk(bus_ad == exp_ad, addr_ph ? "R2 effective address" : "R3 store data", bus_ad, exp_ad);
    endtask

    // Runs one request; called right after a negedge with the block idle.
    task automatic do_op(input bit st, input int r, input int b, input int i,
                         input logic [31:0] val, input int max_wait, input bit noise);
        logic [31:0] addr;
        logic [31:0] data;
        int w;
        addr = model_addr(b, i);
        data = exp_rf[r];
        chk(req_ready == 1'b1, "R8 idle before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_store = st;
        req_base = 5'(b); req_index = 5'(i); req_reg = 5'(r);
        @(negedge clk);
        req_valid = noise;
        if (noise) begin
            req_store = ~st; req_base = 5'($urandom); req_index = 5'($urandom); req_reg = 5'($urandom);
        end
        w = (max_wait > 0) ? $urandom_range(0, max_wait) : 0;
        for (int k = 0; k < w; k++) begin
            bus_ready = 1'b0;
            check_phase(1'b1, st, addr, 1'b1);   // R7 hold
            @(negedge clk);
        end
        bus_ready = 1'b1;
        check_phase(1'b1, st, addr, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        w = (max_wait > 0) ? $urandom_range(0, max_wait) : 0;
        for (int k = 0; k < w; k++) begin
            bus_ready = 1'b0;
            bus_rdata = $urandom;
            check_phase(1'b0, st, data, st);     // R7 hold
            @(negedge clk);
        end
        bus_ready = 1'b1;
        bus_rdata = val;
        check_phase(1'b0, st, data, st);
        @(negedge clk);
        bus_ready = 1'b0;
        bus_rdata = $urandom;
        chk(fetch_stall == 1'b0, "R6 stall drops after last transfer", 32'(fetch_stall), 32'd0);
        chk(bus_valid == 1'b0, "R6 bus released", 32'(bus_valid), 32'd0);
        if (st) begin
            chk(req_ready == 1'b1, "R3 idle after third cycle", 32'(req_ready), 32'd1);
        end else begin
            chk(req_ready == 1'b0, "R4 write-back cycle busy", 32'(req_ready), 32'd0);
            @(negedge clk);
            chk(req_ready == 1'b1, "R4 idle after write-back", 32'(req_ready), 32'd1);
            if (r != 0) exp_rf[r] = val;
        end
        @(negedge clk);
        chk(bus_valid == 1'b0, "R8 no extra transfer", 32'(bus_valid), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 32; k++) exp_rf[k] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(req_ready == 1'b1, "R1 reset req_ready", 32'(req_ready), 32'd1);
        chk(bus_valid == 1'b0, "R1 reset bus_valid", 32'(bus_valid), 32'd0);
        chk(fetch_stall == 1'b0, "R1 reset fetch_stall", 32'(fetch_stall), 32'd0);
        // R1: registers are zero after reset, seen through a store of r7 at r3+r4.
        do_op(1'b1, 7, 3, 4, '0, 0, 1'b0);

        // Directed loads with no bus wait (R4 timing).
        do_op(1'b0, 1, 0, 0, 32'hFFFF_FFF0, 0, 1'b0);
        do_op(1'b0, 2, 0, 0, 32'h0000_0020, 0, 1'b0);
        do_op(1'b0, 3, 1, 2, 32'hA5A5_1234, 0, 1'b0);
        // R5: load into r0 is dropped; store of r0 at r0+r0 gives address 0 and data 0.
        do_op(1'b0, 0, 0, 0, 32'hDEAD_BEEF, 0, 1'b0);
        do_op(1'b1, 0, 0, 0, '0, 0, 1'b0);
        // R2: wrap-around 0xFFFFFFF0 + 0x20 = 0x10; R3 store data of r3.
        do_op(1'b1, 3, 1, 2, '0, 0, 1'b0);
        // Same register as base, index and data.
        do_op(1'b1, 3, 3, 3, '0, 0, 1'b0);

        // Random mix with bus wait states (R7) and ignored requests (R8).
        for (int n = 0; n < 200; n++) begin
            do_op(1'($urandom), int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                  int'($urandom_range(0, 31)), $urandom, 2, 1'($urandom));
        end

        // R9: reset in the middle of a load data phase.
        req_valid = 1'b1; req_store = 1'b0; req_base = 5'd1; req_index = 5'd2; req_reg = 5'd9;
        @(negedge clk);
        req_valid = 1'b0; bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        chk(bus_valid == 1'b1 && bus_addr_phase == 1'b0, "R9 in data phase", 32'(bus_addr_phase), 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(bus_valid == 1'b0, "R9 bus abandoned", 32'(bus_valid), 32'd0);
        chk(req_ready == 1'b1, "R9 idle after reset", 32'(req_ready), 32'd1);
        chk(fetch_stall == 1'b0, "R9 stall cleared", 32'(fetch_stall), 32'd0);
        for (int k = 0; k < 32; k++) exp_rf[k] = '0;
        @(negedge clk);
        do_op(1'b1, 9, 1, 2, '0, 1, 1'b0);
        finish_run();
    end
endmodule